// File: doc/BRIEF.md
# Two-Stage Sampling Interval Counter

This block decides which members of a population of operations are picked for profiling. A primary down-counter measures the base interval. When it runs out, it either selects the current member at once or, with randomisation on, hands off to a short secondary down-counter. The secondary counter's start value comes from an external 8-bit random input, and the sample is taken when that counter expires. Both counters step on the same population pulse. They hold still whenever profiling is disabled.

Software sees the counter state as one 64-bit register, which it can read and write for context save and restore. Software writes zero before a session. The first cycle of the enabled state then fills an empty primary counter from the interval input. The output is a single-cycle select pulse, raised combinationally in the same cycle as the population pulse that it picks.

Top module: `samp_ivl_top`

## Requirements
- R1: After reset the register reads all zeros and `sampleSel` is low.
- R2: The register holds the primary count in bits 31:0 and the secondary count in bits 63:56. Bits 55:32 always read zero, and data written to them is dropped.
- R3: A write (`regWrEn` high) replaces both counts on the next edge. It takes priority over a population pulse or an enable edge in the same cycle, and never raises `sampleSel`.
- R4: In the first cycle `profEn` is high after a cycle with it low, a zero primary count loads `intervalVal`, and a nonzero primary count is kept. A population pulse in that cycle is not counted.
- R5: While enabled (and not in the entry cycle), each population pulse lowers a primary count greater than one by exactly 1.
- R6: While `profEn` is low, population pulses leave the register unchanged and `sampleSel` stays low.
- R7: When a pulse takes the primary count from 1 to 0 with `rndEn` low, `sampleSel` is high in that cycle and the primary count reloads `intervalVal`.
- R8: When a pulse takes the primary count from 1 to 0 with `rndEn` high, the primary count reloads `intervalVal` and the secondary count loads `rndVal`. `sampleSel` is high in that cycle only if `rndVal` is zero.
- R9: While enabled, each counted pulse lowers a nonzero secondary count by 1, alongside the primary count. The pulse that takes the secondary count from 1 to 0 raises `sampleSel`.
- R10: `sampleSel` is high only in a cycle with a counted population pulse (`profEn` high, `popPulse` high, no write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| profEn | input | 1 | Profiling enable level |
| popPulse | input | 1 | One-cycle pulse per population member |
| intervalVal | input | 32 | Reload value for the primary count |
| rndEn | input | 1 | Hand off to the secondary stage on primary expiry |
| rndVal | input | 8 | Random start value for the secondary count |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data |
| sampleSel | output | 1 | Current population member is selected |

## Verification
The assertions assume that `popPulse` is meaningful only in cycles where it is sampled at a clock edge. They also assume that `intervalVal` is nonzero whenever a reload can occur, since a zero interval would leave the primary count stuck at zero. The stimulus drives every input once per cycle, on the falling edge, and always supplies a nonzero interval. It exercises the corner cases where a write, an enable edge, a primary expiry or a secondary expiry meets a pulse in the same cycle.

// File: rtl/samp_ivl_pkg.sv
package samp_ivl_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic wrLoad;     // take register write data
    logic entryLoad;  // fill empty primary on enable entry
    logic primDec;    // primary count minus one
    logic primReload; // primary expired: load interval
    logic secDec;     // secondary count minus one
    logic secLoad;    // hand-off: load random value
  } ivlStrobe_t;
endpackage

// File: rtl/samp_ivl_ctrl.sv
module samp_ivl_ctrl
  import samp_ivl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       profEn,
  input  logic       popPulse,
  input  logic       rndEn,
  input  logic       rndZero,
  input  logic       regWrEn,
  input  logic       primZero,
  input  logic       primOne,
  input  logic       secZero,
  input  logic       secOne,
  output ivlStrobe_t stb,
  output logic       sampleSel
);
  logic prevEn;
  logic entryEdge, counted, primStep, primWrap;

  always_ff @(posedge clk) begin
    if (!rst_n) prevEn <= 1'b0;
    else        prevEn <= profEn;
  end

  always_comb begin
    entryEdge = profEn & ~prevEn & ~regWrEn;
    counted   = profEn & prevEn & popPulse & ~regWrEn;
    primStep  = counted & ~primZero;
    primWrap  = primStep & primOne;

    stb.wrLoad     = regWrEn;
    stb.entryLoad  = entryEdge & primZero;
    stb.primDec    = primStep & ~primOne;
    stb.primReload = primWrap;
    stb.secLoad    = primWrap & rndEn;
    stb.secDec     = counted & ~secZero;

    sampleSel = (stb.secDec & secOne) | (primWrap & (~rndEn | rndZero));
  end

  // R4: at most one primary update chosen per cycle
  p_one_prim_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrLoad, stb.entryLoad, stb.primDec, stb.primReload}));

  // R3: a write cycle never selects
  p_write_no_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> !sampleSel);
endmodule

// File: rtl/samp_ivl_dp.sv
module samp_ivl_dp
  import samp_ivl_pkg::*;
#(
  parameter int PRIM_W = 32,
  parameter int SEC_W  = 8,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ivlStrobe_t        stb,
  input  logic [PRIM_W-1:0] wrPrim,
  input  logic [SEC_W-1:0]  wrSec,
  input  logic [PRIM_W-1:0] intervalVal,
  input  logic [SEC_W-1:0]  rndVal,
  output logic [REG_W-1:0]  regRdData,
  output logic              primZero,
  output logic              primOne,
  output logic              secZero,
  output logic              secOne
);
  localparam int RSVD_W = REG_W - SEC_W - PRIM_W;
  localparam logic [PRIM_W-1:0] PRIM_ONE = PRIM_W'(1);
  localparam logic [SEC_W-1:0]  SEC_ONE  = SEC_W'(1);

  logic [PRIM_W-1:0] primCnt;
  logic [SEC_W-1:0]  secCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primCnt <= '0;
      secCnt  <= '0;
    end else begin
      if (stb.wrLoad)                         primCnt <= wrPrim;
      else if (stb.entryLoad | stb.primReload) primCnt <= intervalVal;
      else if (stb.primDec)                   primCnt <= primCnt - PRIM_ONE;

      if (stb.wrLoad)       secCnt <= wrSec;
      else if (stb.secLoad) secCnt <= rndVal;
      else if (stb.secDec)  secCnt <= secCnt - SEC_ONE;
    end
  end

  assign primZero  = (primCnt == '0);
  assign primOne   = (primCnt == PRIM_ONE);
  assign secZero   = (secCnt == '0);
  assign secOne    = (secCnt == SEC_ONE);
  assign regRdData = {secCnt, {RSVD_W{1'b0}}, primCnt};

  // R3: written values land on the next edge
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrLoad |=> (primCnt == $past(wrPrim)) && (secCnt == $past(wrSec)));

  // R8: hand-off puts the random value in the secondary stage
  p_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.secLoad && !stb.wrLoad) |=> secCnt == $past(rndVal));
endmodule

// File: rtl/samp_ivl_top.sv
module samp_ivl_top
  import samp_ivl_pkg::*;
#(
  parameter int PRIM_W = 32,
  parameter int SEC_W  = 8,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              profEn,
  input  logic              popPulse,
  input  logic [PRIM_W-1:0] intervalVal,
  input  logic              rndEn,
  input  logic [SEC_W-1:0]  rndVal,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              sampleSel
);
  localparam int SEC_LSB = REG_W - SEC_W;

  ivlStrobe_t stb;
  logic primZero, primOne, secZero, secOne;
  logic unusedRsvd;

  assign unusedRsvd = ^regWrData[SEC_LSB-1:PRIM_W];

  samp_ivl_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .profEn(profEn), .popPulse(popPulse),
    .rndEn(rndEn), .rndZero(rndVal == '0), .regWrEn(regWrEn),
    .primZero(primZero), .primOne(primOne), .secZero(secZero), .secOne(secOne),
    .stb(stb), .sampleSel(sampleSel)
  );

  samp_ivl_dp #(.PRIM_W(PRIM_W), .SEC_W(SEC_W), .REG_W(REG_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .wrPrim(regWrData[PRIM_W-1:0]), .wrSec(regWrData[REG_W-1:SEC_LSB]),
    .intervalVal(intervalVal), .rndVal(rndVal),
    .regRdData(regRdData),
    .primZero(primZero), .primOne(primOne), .secZero(secZero), .secOne(secOne)
  );

  // R2: reserved field never reads nonzero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[SEC_LSB-1:PRIM_W] == '0);

  // R6: disabled and not written, the register holds
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!profEn && !regWrEn) |=> $stable(regRdData));

  // R10: select only on a counted pulse
  p_sel_on_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sampleSel |-> (profEn && popPulse && !regWrEn));

  // R5: a plain step lowers the primary count by one
  p_prim_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (profEn && $past(profEn) && popPulse && !regWrEn && regRdData[PRIM_W-1:0] > PRIM_W'(1))
      |=> regRdData[PRIM_W-1:0] == $past(regRdData[PRIM_W-1:0]) - PRIM_W'(1));
endmodule

// File: tb/samp_ivl_top_tb_top.sv
module samp_ivl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        profEn = 1'b0, popPulse = 1'b0, rndEn = 1'b0, regWrEn = 1'b0;
  logic [31:0] intervalVal = '0;
  logic [7:0]  rndVal = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        sampleSel;

  int checks = 0;
  int fails = 0;

  typedef struct {
    string       tag;
    logic        expSel;
    logic [63:0] expReg;
  } item_t;
  item_t expQ[$];

  // bench model state
  logic [31:0] mPrim = '0;
  logic [7:0]  mSec = '0;
  logic        mPrevEn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  samp_ivl_top dut_i (
    .clk(clk), .rst_n(rst_n), .profEn(profEn), .popPulse(popPulse),
    .intervalVal(intervalVal), .rndEn(rndEn), .rndVal(rndVal),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .sampleSel(sampleSel)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus at a falling edge, pushes expectation
  task automatic step(string tag, logic en, logic pulse, logic [31:0] ivl,
                      logic rnd, logic [7:0] rv, logic wr, logic [63:0] wd);
    item_t it;
    logic sel;
    profEn = en; popPulse = pulse; intervalVal = ivl; rndEn = rnd;
    rndVal = rv; regWrEn = wr; regWrData = wd;
    sel = 1'b0;
    if (wr) begin
      mPrim = wd[31:0]; mSec = wd[63:56];
    end else if (en && !mPrevEn) begin
      if (mPrim == 0) mPrim = ivl;
    end else if (en && pulse) begin
      if (mSec != 0) begin
        if (mSec == 1) sel = 1'b1;
        mSec = mSec - 8'd1;
      end
      if (mPrim != 0) begin
        if (mPrim == 1) begin
          mPrim = ivl;
          if (rnd) begin
            mSec = rv;
            if (rv == 0) sel = 1'b1;
          end else sel = 1'b1;
        end else mPrim = mPrim - 32'd1;
      end
    end
    mPrevEn = en;
    it.tag = tag; it.expSel = sel; it.expReg = {mSec, 24'h0, mPrim};
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: select checked in its own cycle, register one cycle later
  initial begin
    item_t held;
    bit pending = 0;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (pending) check(held.tag, "register", regRdData, held.expReg);
      if (expQ.size() > 0) begin
        held = expQ.pop_front();
        check(held.tag, "sampleSel", {63'b0, sampleSel}, {63'b0, held.expSel});
        pending = 1;
      end else pending = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R1", "reset register", regRdData, 64'h0);
    check("R1", "reset sampleSel", {63'b0, sampleSel}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: packing, reserved bits dropped; R3 write wins over pulse
    step("R2", 0, 0, 0, 0, 0, 1, 64'hA5FF_FFFF_0000_0007);
    step("R3", 1, 1, 32'd9, 0, 0, 1, 64'h0000_0000_0000_0000);
    step("R6", 0, 1, 32'd4, 0, 0, 0, 0);
    // R4 entry with zero count loads interval; pulse in entry cycle not counted
    step("R4", 1, 1, 32'd4, 0, 0, 0, 0);
    step("R5", 1, 1, 32'd4, 0, 0, 0, 0);
    step("R5", 1, 0, 32'd4, 0, 0, 0, 0);
    step("R5", 1, 1, 32'd4, 0, 0, 0, 0);
    step("R5", 1, 1, 32'd4, 0, 0, 0, 0);
    // R7 expiry with randomisation off
    step("R7", 1, 1, 32'd4, 0, 0, 0, 0);
    step("R5", 1, 1, 32'd4, 0, 0, 0, 0);
    // R6 frozen while disabled, R10 no select
    step("R6", 0, 1, 32'd4, 0, 0, 0, 0);
    step("R6", 0, 1, 32'd4, 0, 0, 0, 0);
    step("R10", 0, 1, 32'd1, 0, 0, 0, 0);
    // R4 re-entry with nonzero count keeps it
    step("R4", 1, 0, 32'd20, 0, 0, 0, 0);
    step("R5", 1, 1, 32'd5, 1, 8'd3, 0, 0);
    step("R5", 1, 1, 32'd5, 1, 8'd3, 0, 0);
    // R8 hand-off with random 3
    step("R8", 1, 1, 32'd5, 1, 8'd3, 0, 0);
    // R9 parallel decrement, select on secondary expiry
    step("R9", 1, 1, 32'd5, 1, 8'd7, 0, 0);
    step("R9", 1, 0, 32'd5, 1, 8'd7, 0, 0);
    step("R9", 1, 1, 32'd5, 1, 8'd7, 0, 0);
    step("R9", 1, 1, 32'd5, 1, 8'd7, 0, 0);
    // R3 write with pulse mid-session: primary 1, random 0
    step("R3", 1, 1, 32'd5, 1, 8'd0, 1, 64'h0200_0000_0000_0001);
    // R8 random zero selects at once; secondary 2 also steps (R9)
    step("R8", 1, 1, 32'd6, 1, 8'd0, 0, 0);
    step("R9", 1, 1, 32'd6, 1, 8'd0, 0, 0);
    // R3 write on an enable edge: edge consumed, zero count kept
    step("R3", 0, 0, 32'd6, 0, 0, 0, 0);
    step("R3", 1, 1, 32'd6, 0, 0, 1, 64'h0);
    step("R10", 1, 1, 32'd6, 0, 0, 0, 0);
    step("R10", 1, 0, 32'd6, 0, 0, 0, 0);
    step("R10", 1, 0, 32'd6, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule